// File: doc/BRIEF.md
# Programmable UART Bit-Rate Generator

The block turns one master clock into a sampling clock for a serial receiver or transmitter, running at sixteen times a chosen bit rate. A four-bit rate code picks one of thirteen fixed rates, or routes an external level straight to the output so that a user-supplied frequency or a static level ("zero baud") can be used instead. With a 2.4576 MHz master clock the fastest internal rate, 9600 baud, appears at the output as the master clock divided by 16. A slower master clock scales every rate down in proportion.

The master clock comes from one of two sources: a crystal-side level or an external clock level. A selector chooses between them. Both are sampled as levels in the fast system clock domain, and each rising edge of the selected level counts as one master tick. When the external source is selected, the first high level seen on it clears every counter once. Holding the external level high while the crystal source is selected keeps the counters cleared for as long as that lasts. A three-bit prescaler that counts master ticks is exposed, so its top bit (master divided by 8) can be fed back into the external rate input to obtain 19200 baud.

Top module: `baud_clock_gen`

## Requirements
- R1: With `xtal_sel` = 1 the master level is `xtal_in`; with `xtal_sel` = 0 it is `ext_clk_in`. Each rising edge of the selected level is one master tick. `mclk_out` repeats the selected level one `clk` cycle later.
- R2: `pre_tap` counts master ticks modulo 8 and increments by one per tick. Bit 0 is the master clock divided by 2, bit 1 divided by 4, bit 2 divided by 8.
- R3: For rate codes 0 and 1 (`rate_sel[3:1]` = 000), `rate_out` takes the value of `mux_in` sampled at each master tick.
- R4: The other codes give a square wave of exactly 50% duty whose period in master ticks is the nearest integer to 153600 / rate. Rates by code: 2 = 50, 3 = 75, 4 = 134.5, 5 = 200, 6 = 600, 7 = 2400, 8 = 9600, 9 = 4800, 11 = 1200, 12 = 2400, 13 = 300, 14 = 150, 15 = 110.
- R5: Code 10 (1800 baud) repeats the periods 85, 85, 86 master ticks. Every high and every low level lasts 42 or 43 ticks, and any three consecutive periods total 256 ticks.
- R6: `rate_out` changes only on a master tick or a counter clear. A new `rate_sel` takes effect at the next tick, so no level of `rate_out` lasts less than one master tick.
- R7: While `xtal_sel` = 1 and `ext_clk_in` = 1, all counters are held cleared: `pre_tap` = 0 and `rate_out` = 0. Counting resumes once `ext_clk_in` returns low.
- R8: After `xtal_sel` falls, the first high level on `ext_clk_in` clears all counters and `rate_out` for its whole duration, and its rising edge is not counted. Later high levels are counted normally and do not clear.
- R9: A low `rst_n` at a `clk` edge clears `pre_tap`, `rate_out` and `mclk_out` to 0.
- R10: With code 0 and `mux_in` driven from `pre_tap[2]`, `rate_out` has a period of 8 master ticks (19200 baud at the nominal master clock).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all levels |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_sel | input | 1 | 1 selects the crystal-side level, 0 the external clock |
| xtal_in | input | 1 | Crystal-side master clock level |
| ext_clk_in | input | 1 | External master clock level; also drives the clear logic |
| rate_sel | input | 4 | Rate code |
| mux_in | input | 1 | External rate input routed by codes 0 and 1 |
| mclk_out | output | 1 | Selected master clock level, one cycle late |
| pre_tap | output | 3 | Prescaler count of master ticks |
| rate_out | output | 1 | Sampling clock at 16 times the selected bit rate |

## Verification
A wrong count in one of the rate dividers shows up only on `rate_out`, and only while that code is selected. It appears as a period or half-period that is off at the first output edge after the fault, which can be up to 1536 master ticks later for the slowest code. A fault in the prescaler or in the clear logic shows on `pre_tap` at the next master tick. A fault in the 1800-baud step sequence may produce correct individual levels, so it is exposed only by the three-period total. A glitch from a select change would appear as a `rate_out` level shorter than one master tick, immediately after the change.

// File: rtl/baud_gen_pkg.sv
// Package: shared constants, the code-to-half-period table and the
// initialization state type for the bit-rate generator.
// Assumes a 4-bit rate code, with codes below FIRST_DIV_CODE routing the
// external input.
package baud_gen_pkg;

    localparam int SEL_W          = 4;
    localparam int NUM_CODES      = 1 << SEL_W;
    localparam int TAP_W          = 3;
    localparam int FIRST_DIV_CODE = 2;
    localparam int FRAC_CODE      = 10;
    localparam int MAX_HALF       = 1536;
    localparam int HALF_W         = $clog2(MAX_HALF + 1);
    localparam int FRAC_STEPS     = 6;
    localparam int FRAC_BASE_HALF = 42;
    // bit i set: half-period i of the cycle is one tick longer than the base
    localparam logic [FRAC_STEPS-1:0] FRAC_LONG_MASK = 6'b110101;

    // Half-period in master ticks for each integer-divided rate code.
    function automatic int half_period(input int code);
        case (code)
            2:       return 1536;  // 50
            3:       return 1024;  // 75
            4:       return 571;   // 134.5
            5:       return 384;   // 200
            6:       return 128;   // 600
            7:       return 32;    // 2400
            8:       return 8;     // 9600
            9:       return 16;    // 4800
            11:      return 64;    // 1200
            12:      return 32;    // 2400
            13:      return 256;   // 300
            14:      return 512;   // 150
            15:      return 698;   // 110
            default: return 1;
        endcase
    endfunction

    typedef enum logic [1:0] {
        INIT_IDLE     = 2'd0,
        INIT_ARMED    = 2'd1,
        INIT_CLEARING = 2'd2
    } init_state_e;

endpackage

// File: rtl/baud_clk_src.sv
// Module: master clock source selection, tick extraction and counter clear.
// Assumes both clock sources are levels that are slow compared with clk.
// Produces one-cycle tick pulses on rising edges of the selected level. The
// clear is either continuous (crystal selected with the external level high)
// or a one-shot over the first external high level after the selector falls.
module baud_clk_src
    import baud_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_sel,
    input  logic xtal_in,
    input  logic ext_clk_in,
    output logic mclk_lvl,
    output logic tick,
    output logic cnt_clr
);

    logic        src_lvl;
    logic        mclk_q;
    logic        sel_q;
    logic        sel_fell;
    init_state_e st_q;
    init_state_e st_d;

    // Pick the level of the selected source.
    always_comb src_lvl = xtal_sel ? xtal_in : ext_clk_in;

    // Remember the previous selected level and selector value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mclk_q <= 1'b0;
            sel_q  <= xtal_sel;
        end else begin
            mclk_q <= src_lvl;
            sel_q  <= xtal_sel;
        end
    end

    // Rising edge of the selected level is one master tick.
    always_comb tick = src_lvl & ~mclk_q;

    // Falling edge of the selector arms the one-shot clear.
    always_comb sel_fell = sel_q & ~xtal_sel;

    // Next state of the one-shot clear sequencer.
    always_comb begin
        st_d = st_q;
        case (st_q)
            INIT_IDLE:     if (sel_fell) st_d = INIT_ARMED;
            INIT_ARMED: begin
                if (xtal_sel)        st_d = INIT_IDLE;
                else if (ext_clk_in) st_d = INIT_CLEARING;
            end
            INIT_CLEARING: if (xtal_sel || !ext_clk_in) st_d = INIT_IDLE;
            default:       st_d = INIT_IDLE;
        endcase
    end

    // State register of the one-shot clear sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= INIT_IDLE;
        else        st_q <= st_d;
    end

    // Clear on the continuous condition or during the first external high level.
    always_comb begin
        cnt_clr = (xtal_sel & ext_clk_in)
                | ((st_q == INIT_ARMED) & ~xtal_sel & ext_clk_in)
                | (st_q == INIT_CLEARING);
    end

    assign mclk_lvl = mclk_q;

endmodule

// File: rtl/baud_prescale.sv
// Module: prescaler counting master ticks; its bits are the divide-by-2, -4
// and -8 taps. Assumes tick is a single-cycle pulse.
module baud_prescale #(
    parameter int TAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    output logic [TAP_W-1:0] tap
);

    logic [TAP_W-1:0] cnt_q;

    // Count ticks, wrapping at 2**TAP_W.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (tick)     cnt_q <= cnt_q + TAP_W'(1);
    end

    assign tap = cnt_q;

endmodule

// File: rtl/baud_div.sv
// Module: integer half-period divider. Toggles its output every HALF master
// ticks, giving an exact 50% duty. Assumes HALF >= 1 and fits in CNT_W bits.
module baud_div #(
    parameter int HALF  = 8,
    parameter int CNT_W = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic out
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             out_q;

    // Count ticks within a half-period and toggle at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (tick) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                out_q <= ~out_q;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign out = out_q;

endmodule

// File: rtl/baud_div_frac.sv
// Module: fractional divider. Steps through STEPS half-periods, each BASE or
// BASE+1 ticks long as LONG_MASK says, to approximate a non-integer divisor.
// Assumes STEPS is even, so the output phase repeats every cycle of steps.
module baud_div_frac #(
    parameter int               BASE      = 42,
    parameter int               STEPS     = 6,
    parameter logic [STEPS-1:0] LONG_MASK = 6'b110101,
    parameter int               CNT_W     = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic out
);

    localparam int                STEP_W    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [STEP_W-1:0] step_q;
    logic              out_q;
    logic [CNT_W-1:0]  last_cnt;

    // Last count value of the current half-period.
    always_comb begin
        last_cnt = CNT_W'(BASE - 1);
        if (LONG_MASK[step_q]) last_cnt = CNT_W'(BASE);
    end

    // Count ticks, toggle at the end of each half-period and advance the step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q  <= '0;
            step_q <= '0;
            out_q  <= 1'b0;
        end else if (tick) begin
            if (cnt_q == last_cnt) begin
                cnt_q  <= '0;
                out_q  <= ~out_q;
                step_q <= (step_q == LAST_STEP) ? '0 : step_q + STEP_W'(1);
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign out = out_q;

endmodule

// File: rtl/baud_out_mux.sv
// Module: registered rate selector. On each master tick it loads either the
// external input or one divider output, so the result changes only on ticks.
// Assumes the divider bus is indexed by rate code.
module baud_out_mux #(
    parameter int SEL_W      = 4,
    parameter int NUM_CODES  = 16,
    parameter int FIRST_DIV  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 clr,
    input  logic [SEL_W-1:0]     rate_sel,
    input  logic                 mux_in,
    input  logic [NUM_CODES-1:0] div_bus,
    output logic                 z
);

    logic z_q;
    logic z_d;

    // Choose the source of the next output level.
    always_comb begin
        if (32'(rate_sel) < FIRST_DIV) z_d = mux_in;
        else                           z_d = div_bus[rate_sel];
    end

    // Load the output only on master ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) z_q <= 1'b0;
        else if (tick)     z_q <= z_d;
    end

    assign z = z_q;

endmodule

// File: rtl/baud_clock_gen.sv
// Module: top of the programmable bit-rate generator. Joins source selection,
// the prescaler, a bank of free-running rate dividers (one per code) and the
// registered output selector. Assumes all inputs are synchronous to clk.
module baud_clock_gen
    import baud_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_sel,
    input  logic             xtal_in,
    input  logic             ext_clk_in,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             mux_in,
    output logic             mclk_out,
    output logic [TAP_W-1:0] pre_tap,
    output logic             rate_out
);

    logic                 tick;
    logic                 cnt_clr;
    logic [NUM_CODES-1:0] div_bus;

    baud_clk_src u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .xtal_sel   (xtal_sel),
        .xtal_in    (xtal_in),
        .ext_clk_in (ext_clk_in),
        .mclk_lvl   (mclk_out),
        .tick       (tick),
        .cnt_clr    (cnt_clr)
    );

    baud_prescale #(.TAP_W(TAP_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clr   (cnt_clr),
        .tap   (pre_tap)
    );

    for (genvar c = 0; c < NUM_CODES; c++) begin : g_rate
        if (c < FIRST_DIV_CODE) begin : g_ext
            assign div_bus[c] = 1'b0;
        end else if (c == FRAC_CODE) begin : g_frac
            baud_div_frac #(
                .BASE      (FRAC_BASE_HALF),
                .STEPS     (FRAC_STEPS),
                .LONG_MASK (FRAC_LONG_MASK),
                .CNT_W     (HALF_W)
            ) u_div (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick),
                .clr   (cnt_clr),
                .out   (div_bus[c])
            );
        end else begin : g_int
            baud_div #(
                .HALF  (half_period(c)),
                .CNT_W (HALF_W)
            ) u_div (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick),
                .clr   (cnt_clr),
                .out   (div_bus[c])
            );
        end
    end

    baud_out_mux #(
        .SEL_W     (SEL_W),
        .NUM_CODES (NUM_CODES),
        .FIRST_DIV (FIRST_DIV_CODE)
    ) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clr      (cnt_clr),
        .rate_sel (rate_sel),
        .mux_in   (mux_in),
        .div_bus  (div_bus),
        .z        (rate_out)
    );

endmodule

// File: rtl/baud_clock_gen_chk.sv
// Module: assertion checker for the bit-rate generator, bound to the top.
// Observes ports plus the tick and clear nets between submodules.
module baud_clock_gen_chk
    import baud_gen_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             xtal_sel,
    input logic             ext_clk_in,
    input logic [SEL_W-1:0] rate_sel,
    input logic             mux_in,
    input logic [TAP_W-1:0] pre_tap,
    input logic             rate_out,
    input logic             tick_w,
    input logic             clr_w
);

    AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick_w) && !$past(clr_w))
            |-> pre_tap == TAP_W'($past(pre_tap) + TAP_W'(1)));  // R2

    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick_w) && !$past(clr_w)) |-> $stable(pre_tap));  // R2

    AST_MUX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick_w) && !$past(clr_w) && ($past(rate_sel[SEL_W-1:1]) == '0))
            |-> rate_out == $past(mux_in));  // R3

    AST_Z_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(rate_out)) |-> ($past(tick_w) || $past(clr_w)));  // R6

    AST_CONT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (xtal_sel && ext_clk_in) |=> (pre_tap == '0 && !rate_out));  // R7

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> (pre_tap == '0 && !rate_out));  // R8

endmodule

bind baud_clock_gen baud_clock_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xtal_sel   (xtal_sel),
    .ext_clk_in (ext_clk_in),
    .rate_sel   (rate_sel),
    .mux_in     (mux_in),
    .pre_tap    (pre_tap),
    .rate_out   (rate_out),
    .tick_w     (tick),
    .clr_w      (cnt_clr)
);

// File: tb/baud_clock_gen_tb_top.sv
`timescale 1ns/1ps
module baud_clock_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xtal_sel = 1'b1;
    logic       xtal_in = 1'b0;
    logic       ext_clk_in = 1'b0;
    logic [3:0] rate_sel = 4'd8;
    logic       mux_man = 1'b0;
    logic       loop_en = 1'b0;
    logic       xtal_run = 1'b0;
    logic       mux_in;
    logic       mclk_out;
    logic [2:0] pre_tap;
    logic       rate_out;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    logic mon_en = 1'b0;
    logic mon_prev = 1'b0;
    int   mon_run = 2;
    int   mon_bad = 0;

    assign mux_in = loop_en ? pre_tap[2] : mux_man;

    baud_clock_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .xtal_sel   (xtal_sel),
        .xtal_in    (xtal_in),
        .ext_clk_in (ext_clk_in),
        .rate_sel   (rate_sel),
        .mux_in     (mux_in),
        .mclk_out   (mclk_out),
        .pre_tap    (pre_tap),
        .rate_out   (rate_out)
    );

    always #2.5 clk = ~clk;

    // Free-running crystal level: one master tick every two clk cycles.
    always @(negedge clk) if (xtal_run) xtal_in <= ~xtal_in;

    // Shortest-level monitor for R6.
    always @(negedge clk) begin
        if (mon_en) begin
            if (rate_out != mon_prev) begin
                if (mon_run < 2) mon_bad++;
                mon_run = 1;
            end else begin
                mon_run++;
            end
        end
        mon_prev = rate_out;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: act=%0d cycles exp<190000", cyc);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // Count negedges until rate_out reaches lvl.
    task automatic wait_lvl(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rate_out != lvl && n < 20000);
    endtask

    function automatic real rate_of(input int code);
        case (code)
            2: return 50.0;    3: return 75.0;   4: return 134.5;
            5: return 200.0;   6: return 600.0;  7: return 2400.0;
            8: return 9600.0;  9: return 4800.0; 10: return 1800.0;
            11: return 1200.0; 12: return 2400.0; 13: return 300.0;
            14: return 150.0;  15: return 110.0;
            default: return 1.0;
        endcase
    endfunction

    // Align to a true rising edge of rate_out after a code change.
    task automatic align();
        int n;
        wait_lvl(1'b1, n);
        wait_lvl(1'b0, n);
        wait_lvl(1'b1, n);
    endtask

    task automatic pulse_xtal();
        @(negedge clk) xtal_in = 1'b1;
        @(negedge clk) xtal_in = 1'b0;
    endtask

    task automatic pulse_ext();
        @(negedge clk) ext_clk_in = 1'b1;
        @(negedge clk);
        @(negedge clk) ext_clk_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int hi, lo, half, exp_total, tot;
        int h[6];
        bit ok, any;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pre_tap == 3'd0, "R9", "pre_tap after reset", pre_tap, 0);
        check(rate_out == 1'b0, "R9", "rate_out after reset", rate_out, 0);
        check(mclk_out == 1'b0, "R9", "mclk_out after reset", mclk_out, 0);

        // R1/R2: manual crystal ticks.
        @(negedge clk) xtal_in = 1'b1;
        @(negedge clk);
        check(mclk_out == 1'b1, "R1", "mclk_out follows crystal level", mclk_out, 1);
        check(pre_tap == 3'd1, "R2", "pre_tap after one tick", pre_tap, 1);
        xtal_in = 1'b0;
        for (int i = 0; i < 9; i++) pulse_xtal();
        @(negedge clk);
        check(pre_tap == 3'd2, "R2", "pre_tap after ten ticks wraps mod 8", pre_tap, 2);

        // R4/R5/R6: sweep every internal rate.
        xtal_run = 1'b1;
        mon_en = 1'b1;
        for (int c = 2; c < 16; c++) begin
            @(negedge clk) rate_sel = 4'(c);
            align();
            if (c == 10) begin
                exp_total = 2 * $rtoi(3.0 * 153600.0 / rate_of(c) + 0.5);
                tot = 0;
                ok = 1'b1;
                for (int k = 0; k < 6; k++) begin
                    wait_lvl(k[0] ? 1'b1 : 1'b0, h[k]);
                    tot += h[k];
                    if (h[k] != 84 && h[k] != 86) ok = 1'b0;
                    check(h[k] == 84 || h[k] == 86, "R5", "1800 half-period (clk cycles)", h[k], 85);
                end
                check(tot == exp_total, "R5", "1800 three-period total", tot, exp_total);
            end else begin
                half = $rtoi(153600.0 / rate_of(c) + 0.5) / 2;
                wait_lvl(1'b0, hi);
                wait_lvl(1'b1, lo);
                check(hi == 2 * half, "R4", $sformatf("code %0d high time", c), hi, 2 * half);
                check(lo == 2 * half, "R4", $sformatf("code %0d low time", c), lo, 2 * half);
            end
        end
        mon_en = 1'b0;
        check(mon_bad == 0, "R6", "levels shorter than one tick", mon_bad, 0);

        // R3: pass-through for codes 0 and 1.
        for (int c = 0; c < 2; c++) begin
            @(negedge clk) rate_sel = 4'(c);
            for (int v = 0; v < 4; v++) begin
                @(negedge clk) mux_man = ~v[0];
                repeat (3) @(negedge clk);
                check(rate_out == mux_man, "R3", $sformatf("code %0d pass-through", c),
                      rate_out, mux_man);
            end
        end

        // R10: tap bit 2 looped back gives 8-tick period.
        @(negedge clk) begin rate_sel = 4'd0; loop_en = 1'b1; end
        align();
        wait_lvl(1'b0, hi);
        wait_lvl(1'b1, lo);
        check(hi + lo == 16, "R10", "looped tap period (clk cycles)", hi + lo, 16);
        loop_en = 1'b0;

        // R7: continuous clear.
        @(negedge clk) begin rate_sel = 4'd8; ext_clk_in = 1'b1; end
        @(negedge clk);
        ok = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (pre_tap != 3'd0 || rate_out != 1'b0) ok = 1'b0;
        end
        check(ok, "R7", "counters held cleared", int'(pre_tap), 0);
        @(negedge clk) ext_clk_in = 1'b0;
        any = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pre_tap != 3'd0) any = 1'b1;
        end
        check(any, "R7", "counting resumes after release", int'(any), 1);

        // R8: one-shot clear on the first external high level.
        xtal_run = 1'b0;
        @(negedge clk) xtal_in = 1'b0;
        @(negedge clk) xtal_sel = 1'b0;
        repeat (2) @(negedge clk);
        @(negedge clk) ext_clk_in = 1'b1;
        @(negedge clk);
        check(mclk_out == 1'b1, "R1", "mclk_out follows external level", mclk_out, 1);
        check(pre_tap == 3'd0, "R8", "first high level clears", pre_tap, 0);
        @(negedge clk) ext_clk_in = 1'b0;
        repeat (2) @(negedge clk);
        check(pre_tap == 3'd0, "R8", "first rising edge not counted", pre_tap, 0);
        for (int i = 0; i < 11; i++) pulse_ext();
        check(pre_tap == 3'd3, "R8", "later high levels counted, no clear", pre_tap, 3);
        check(rate_out == 1'b1, "R8", "9600 output after 11 ticks from clear", rate_out, 1);

        summary();
    end

endmodule